// File: doc/BRIEF.md
# Serial Flash Controller Register and FIFO Front-End

This block is the memory-mapped face of a multi-lane serial flash controller. Software reaches it over a plain 32-bit register bus with address, write strobe, read strobe, write data and read data. The block holds the setup registers, which are a control word, a frame descriptor, the upper half of the frame byte total and an interrupt mask. It also holds a status word whose event bits are cleared by writing one to them. Two 16-byte FIFOs sit behind the data ports. The transmit FIFO is filled by the host and drained one byte at a time by the frame sequencer. The receive FIFO is filled by the sequencer and drained by the host.

Each FIFO has a byte-wide data port and a word-wide data port. A control flag lets one word-port access move four bytes at once, with the lowest byte first in time. While that flag is set, the empty and full flags are judged against four bytes instead of one. A write of the frame descriptor, made while the controller is enabled and is bus master, sends a one-cycle start pulse to the sequencer. The serial shifting itself lies outside this block. The block combines the enabled status bits into one registered interrupt line.

Top module: `spi_regfile_fifo`

## Requirements
- R1: The control word at offset 0x00 resets to 0. It keeps only these bits: enable (bit 0), master (bit 1), clock idle level (bit 10), quad width (bit 13), lane mode (bits 15:14), four-byte access (bit 16) and clock divider (bits 27:24). All other bits read back as 0.
- R2: The frame descriptor at offset 0x04 keeps all 32 bits. The frame-upper register at offset 0x50 keeps bits 31:16, and its bits 15:0 read back as 0. The interrupt mask at offset 0x0C keeps bits 5:0.
- R3: A write to offset 0x04 drives frame_start high for exactly the one cycle after the write, and only when enable and master are both set. No other write raises frame_start.
- R4: A write to the transmit byte port at offset 0x44 pushes bits 7:0 of the write data. A read of the receive byte port at offset 0x40 pops one byte and returns it in bits 7:0, with the upper bits 0. Read data appears in the cycle after the read strobe.
- R5: While four-byte access (control bit 16) is set, a write to the transmit word port at offset 0x4C pushes four bytes, starting with bits 7:0. A read of the receive word port at offset 0x48 pops four bytes and returns the oldest byte in bits 7:0.
- R6: While four-byte access is clear, the word ports move a single byte, the same as the byte ports. The byte ports always move a single byte.
- R7: The status word at offset 0x10 has these bits:
  - bit 3: set while the transmit FIFO is not full.
  - bit 4: the receive FIFO is empty. This means zero bytes, or fewer than four bytes while four-byte access is set.
  - bit 5: the transmit FIFO is full. This means no free slot, or fewer than four free slots while four-byte access is set.
  - bit 7: ready, set while seq_busy is low.
  - bit 8: a copy of control bit 16.
- R8: Status bits 0 (transmit done), 1 (receive done) and 2 (receive byte arrived) are sticky. They are set by seq_tx_done, by seq_rx_done and by an accepted rx_push. Writing 1 to one of these bits at offset 0x10 clears it, and writing 0 leaves it unchanged. A set event wins over a clear in the same cycle.
- R9: irq is a registered OR of status bits 5:0, each masked by the matching bit of the interrupt mask.
- R10: Each FIFO holds 16 bytes.
  - A receive-port read that would take more bytes than the FIFO holds returns 0 and pops nothing.
  - A transmit-port write that needs more free slots than the FIFO has is dropped entirely.
  - On the sequencer side, a pop from an empty FIFO and a push into a full one are ignored.
- R11: A control write that changes enable from 1 to 0 empties both FIFOs. They are empty from the second cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq | output | 1 | Interrupt request |
| frame_start | output | 1 | One-cycle frame start pulse to the sequencer |
| cfg_ctrl | output | 32 | Current control word |
| cfg_frames | output | 32 | Current frame descriptor |
| cfg_frames_hi | output | 32 | Current frame-upper register |
| tx_pop | input | 1 | Sequencer takes the head transmit byte |
| tx_byte | output | 8 | Head byte of the transmit FIFO |
| tx_nonempty | output | 1 | Transmit FIFO holds at least one byte |
| rx_push | input | 1 | Sequencer delivers a received byte |
| rx_byte | input | 8 | Received byte |
| rx_full | output | 1 | Receive FIFO has no free slot |
| seq_busy | input | 1 | Sequencer is in the middle of a frame |
| seq_tx_done | input | 1 | Transmit-done event pulse |
| seq_rx_done | input | 1 | Receive-done event pulse |

## Verification
The assertions assume that the register bus holds one access per cycle, and that the sequencer pulses tx_pop and rx_push for one cycle at a time. Under those assumptions every FIFO count stays within depth, and the sticky-bit checks can rely on a write to the status offset carrying a defined data word. The bench drives each strobe as a single-cycle pulse from a task. It never asserts read and write together, and it waits out the pipeline register of the flush before it looks at the FIFO side. This keeps all stimulus inside those assumptions while still reaching the full, empty and four-byte threshold edges.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;
  localparam int DW = 32;
  localparam int LANES = DW / 8;

  localparam int OFS_CTRL   = 'h00;
  localparam int OFS_FRAMES = 'h04;
  localparam int OFS_IEN    = 'h0C;
  localparam int OFS_STAT   = 'h10;
  localparam int OFS_RXB    = 'h40;
  localparam int OFS_TXB    = 'h44;
  localparam int OFS_RXW    = 'h48;
  localparam int OFS_TXW    = 'h4C;
  localparam int OFS_FUP    = 'h50;

  localparam int CB_EN  = 0;
  localparam int CB_MST = 1;
  localparam int CB_X4  = 16;
  localparam logic [DW-1:0] CTRL_KEEP = 32'h0F01_E403;
  localparam logic [DW-1:0] FUP_KEEP  = 32'hFFFF_0000;

  localparam int IEN_W     = 6;
  localparam int EVT_W     = 3;
  localparam int ST_TXAV   = 3;
  localparam int ST_RXEMP  = 4;
  localparam int ST_TXFULL = 5;
  localparam int ST_READY  = 7;
  localparam int ST_X4     = 8;
endpackage

// File: rtl/spi_rf_fifo.sv
module spi_rf_fifo #(
  parameter int DEPTH = 16,
  parameter int LANES = 4,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int NW = $clog2(LANES + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic [NW-1:0]      push_n,
  input  logic [8*LANES-1:0] push_data,
  input  logic [NW-1:0]      pop_n,
  output logic [8*LANES-1:0] head_data,
  output logic [CW-1:0]      count
);
  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (NW'(i) < push_n) mem[wr_ptr + PW'(i)] <= push_data[8*i +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr + PW'(push_n);
      rd_ptr <= rd_ptr + PW'(pop_n);
      count  <= count + CW'(push_n) - CW'(pop_n);
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_head
    assign head_data[8*g +: 8] = mem[rd_ptr + PW'(g)];
  end
endmodule

// File: rtl/spi_rf_cfg.sv
module spi_rf_cfg
  import spi_rf_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     ctrl_q,
  output logic [DW-1:0]     frames_q,
  output logic [DW-1:0]     fup_q,
  output logic [IEN_W-1:0]  ien_q,
  output logic              start_q,
  output logic              flush_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      frames_q <= '0;
      fup_q    <= '0;
      ien_q    <= '0;
      start_q  <= 1'b0;
      flush_q  <= 1'b0;
    end else begin
      start_q <= 1'b0;
      flush_q <= 1'b0;
      if (wr_en) begin
        if (addr == ADDR_W'(OFS_CTRL)) begin
          ctrl_q  <= wdata & CTRL_KEEP;
          flush_q <= ctrl_q[CB_EN] & ~wdata[CB_EN];
        end
        if (addr == ADDR_W'(OFS_FRAMES)) begin
          frames_q <= wdata;
          start_q  <= ctrl_q[CB_EN] & ctrl_q[CB_MST];
        end
        if (addr == ADDR_W'(OFS_FUP)) fup_q <= wdata & FUP_KEEP;
        if (addr == ADDR_W'(OFS_IEN)) ien_q <= wdata[IEN_W-1:0];
      end
    end
  end
endmodule

// File: rtl/spi_rf_status.sv
module spi_rf_status
  import spi_rf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [EVT_W-1:0] ev_set,
  input  logic             clr_en,
  input  logic [EVT_W-1:0] clr_mask,
  input  logic             tx_full,
  input  logic             rx_empty,
  input  logic             ready,
  input  logic             x4,
  input  logic [IEN_W-1:0] ien,
  output logic [DW-1:0]    status_word,
  output logic [EVT_W-1:0] evt_q,
  output logic             irq_q
);
  always_comb begin
    status_word                = '0;
    status_word[EVT_W-1:0]     = evt_q;
    status_word[ST_TXAV]       = ~tx_full;
    status_word[ST_RXEMP]      = rx_empty;
    status_word[ST_TXFULL]     = tx_full;
    status_word[ST_READY]      = ready;
    status_word[ST_X4]         = x4;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      evt_q <= (evt_q & ~(clr_en ? clr_mask : '0)) | ev_set;
      irq_q <= |(status_word[IEN_W-1:0] & ien);
    end
  end
endmodule

// File: rtl/spi_regfile_fifo.sv
module spi_regfile_fifo
  import spi_rf_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int NW = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq,
  output logic              frame_start,
  output logic [DW-1:0]     cfg_ctrl,
  output logic [DW-1:0]     cfg_frames,
  output logic [DW-1:0]     cfg_frames_hi,
  input  logic              tx_pop,
  output logic [7:0]        tx_byte,
  output logic              tx_nonempty,
  input  logic              rx_push,
  input  logic [7:0]        rx_byte,
  output logic              rx_full,
  input  logic              seq_busy,
  input  logic              seq_tx_done,
  input  logic              seq_rx_done
);
  logic [DW-1:0]    ctrl_q, frames_q, fup_q, status_word;
  logic [IEN_W-1:0] ien_q;
  logic [EVT_W-1:0] evt_q;
  logic             flush_p;
  logic [CW-1:0]    tx_cnt, rx_cnt, tx_free;
  logic [NW-1:0]    tx_push_n, tx_pop_n, rx_push_n, rx_pop_n;
  logic [DW-1:0]    tx_head, rx_head;
  logic             x4, tx_full_flag, rx_empty_flag, rx_accept;
  logic             sel_rxb, sel_rxw, sel_txb, sel_txw;

  spi_rf_cfg #(.ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .ctrl_q(ctrl_q), .frames_q(frames_q), .fup_q(fup_q), .ien_q(ien_q),
    .start_q(frame_start), .flush_q(flush_p)
  );

  assign x4      = ctrl_q[CB_X4];
  assign tx_free = CW'(DEPTH) - tx_cnt;
  assign sel_rxb = bus_addr == ADDR_W'(OFS_RXB);
  assign sel_rxw = bus_addr == ADDR_W'(OFS_RXW);
  assign sel_txb = bus_addr == ADDR_W'(OFS_TXB);
  assign sel_txw = bus_addr == ADDR_W'(OFS_TXW);

  assign tx_full_flag  = x4 ? (tx_free < CW'(LANES)) : (tx_free == '0);
  assign rx_empty_flag = x4 ? (rx_cnt < CW'(LANES)) : (rx_cnt == '0);

  // host side of the transmit FIFO: word port moves LANES bytes in four-byte mode
  always_comb begin
    tx_push_n = '0;
    if (bus_wr) begin
      if (sel_txw && x4) begin
        if (tx_free >= CW'(LANES)) tx_push_n = NW'(LANES);
      end else if (sel_txb || sel_txw) begin
        if (tx_free != '0) tx_push_n = NW'(1);
      end
    end
  end

  // host side of the receive FIFO
  always_comb begin
    rx_pop_n = '0;
    if (bus_rd) begin
      if (sel_rxw && x4) begin
        if (rx_cnt >= CW'(LANES)) rx_pop_n = NW'(LANES);
      end else if (sel_rxb || sel_rxw) begin
        if (rx_cnt != '0) rx_pop_n = NW'(1);
      end
    end
  end

  assign tx_pop_n  = (tx_pop && tx_cnt != '0) ? NW'(1) : '0;
  assign rx_accept = rx_push && (rx_cnt != CW'(DEPTH));
  assign rx_push_n = rx_accept ? NW'(1) : '0;

  spi_rf_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_txq (
    .clk(clk), .rst(rst), .flush(flush_p), .push_n(tx_push_n),
    .push_data(bus_wdata), .pop_n(tx_pop_n), .head_data(tx_head), .count(tx_cnt)
  );

  spi_rf_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_rxq (
    .clk(clk), .rst(rst), .flush(flush_p), .push_n(rx_push_n),
    .push_data({{(DW-8){1'b0}}, rx_byte}), .pop_n(rx_pop_n), .head_data(rx_head),
    .count(rx_cnt)
  );

  spi_rf_status u_stat (
    .clk(clk), .rst(rst),
    .ev_set({rx_accept, seq_rx_done, seq_tx_done}),
    .clr_en(bus_wr && bus_addr == ADDR_W'(OFS_STAT)),
    .clr_mask(bus_wdata[EVT_W-1:0]),
    .tx_full(tx_full_flag), .rx_empty(rx_empty_flag), .ready(~seq_busy), .x4(x4),
    .ien(ien_q), .status_word(status_word), .evt_q(evt_q), .irq_q(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= '0;
      if (bus_addr == ADDR_W'(OFS_CTRL))   bus_rdata <= ctrl_q;
      if (bus_addr == ADDR_W'(OFS_FRAMES)) bus_rdata <= frames_q;
      if (bus_addr == ADDR_W'(OFS_FUP))    bus_rdata <= fup_q;
      if (bus_addr == ADDR_W'(OFS_IEN))    bus_rdata <= DW'(ien_q);
      if (bus_addr == ADDR_W'(OFS_STAT))   bus_rdata <= status_word;
      if (sel_rxb || sel_rxw) begin
        if (rx_pop_n == NW'(LANES))  bus_rdata <= rx_head;
        else if (rx_pop_n == NW'(1)) bus_rdata <= DW'(rx_head[7:0]);
      end
    end
  end

  assign cfg_ctrl      = ctrl_q;
  assign cfg_frames    = frames_q;
  assign cfg_frames_hi = fup_q;
  assign tx_byte       = tx_head[7:0];
  assign tx_nonempty   = tx_cnt != '0;
  assign rx_full       = rx_cnt == CW'(DEPTH);
endmodule

// File: rtl/spi_regfile_fifo_chk.sv
module spi_regfile_fifo_chk
  import spi_rf_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 8,
  parameter int CW     = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DW-1:0]     bus_wdata,
  input logic [DW-1:0]     bus_rdata,
  input logic              irq,
  input logic              frame_start,
  input logic [IEN_W-1:0]  ien,
  input logic [EVT_W-1:0]  evt,
  input logic              seq_tx_done,
  input logic [CW-1:0]     tx_cnt,
  input logic [CW-1:0]     rx_cnt,
  input logic              flush
);
  assert_start_after_frames_R3: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> ($past(bus_wr) && $past(bus_addr) == ADDR_W'(OFS_FRAMES)));

  assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFS_STAT) && bus_wdata[0] && !seq_tx_done) |=> !evt[0]);

  assert_w0_keeps_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFS_STAT) && !bus_wdata[0] && evt[0]) |=> evt[0]);

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (rst)
    (ien == '0) |=> !irq);

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

  assert_empty_read_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(OFS_RXB) && rx_cnt == '0) |=> (bus_rdata == '0));

  assert_flush_empties_R11: assert property (@(posedge clk) disable iff (rst)
    flush |=> (tx_cnt == '0 && rx_cnt == '0));
endmodule

bind spi_regfile_fifo spi_regfile_fifo_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .frame_start(frame_start),
  .ien(ien_q), .evt(evt_q), .seq_tx_done(seq_tx_done), .tx_cnt(tx_cnt),
  .rx_cnt(rx_cnt), .flush(flush_p)
);

// File: tb/spi_regfile_fifo_test.sv
module spi_regfile_fifo_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, cfg_ctrl, cfg_frames, cfg_frames_hi;
  logic        irq, frame_start, tx_nonempty, rx_full;
  logic [7:0]  tx_byte;
  logic        tx_pop = 1'b0, rx_push = 1'b0, seq_busy = 1'b0;
  logic        seq_tx_done = 1'b0, seq_rx_done = 1'b0;
  logic [7:0]  rx_byte = '0;

  int n_chk = 0, n_bad = 0;
  logic last_start;
  bit   done = 0;

  always #10 clk = ~clk;

  spi_regfile_fifo uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .frame_start(frame_start),
    .cfg_ctrl(cfg_ctrl), .cfg_frames(cfg_frames), .cfg_frames_hi(cfg_frames_hi),
    .tx_pop(tx_pop), .tx_byte(tx_byte), .tx_nonempty(tx_nonempty),
    .rx_push(rx_push), .rx_byte(rx_byte), .rx_full(rx_full),
    .seq_busy(seq_busy), .seq_tx_done(seq_tx_done), .seq_rx_done(seq_rx_done)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; last_start = frame_start;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic push_rx(input logic [7:0] b);
    @(negedge clk); rx_byte = b; rx_push = 1'b1;
    @(negedge clk); rx_push = 1'b0;
  endtask

  task automatic pop_tx(output logic [7:0] b);
    @(negedge clk); b = tx_byte; tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
  endtask

  // vector: {op, req, addr, data, expected}; op 0 = write, 1 = read and compare
  localparam int NV = 13;
  localparam logic [77:0] VEC [NV] = '{
    {2'd0, 4'd1, 8'h00, 32'hFFFF_FFFF, 32'h0},          // R1 write all ones
    {2'd1, 4'd1, 8'h00, 32'h0, 32'h0F01_E403},          // R1 only kept bits
    {2'd0, 4'd1, 8'h00, 32'h0000_0003, 32'h0},
    {2'd1, 4'd1, 8'h00, 32'h0, 32'h0000_0003},
    {2'd0, 4'd2, 8'h04, 32'h1234_5678, 32'h0},          // R2 frames
    {2'd1, 4'd2, 8'h04, 32'h0, 32'h1234_5678},
    {2'd0, 4'd2, 8'h50, 32'hABCD_EF01, 32'h0},          // R2 frames upper
    {2'd1, 4'd2, 8'h50, 32'h0, 32'hABCD_0000},
    {2'd0, 4'd2, 8'h0C, 32'hFFFF_FFFF, 32'h0},          // R2 mask
    {2'd1, 4'd2, 8'h0C, 32'h0, 32'h0000_003F},
    {2'd0, 4'd2, 8'h0C, 32'h0, 32'h0},
    {2'd1, 4'd2, 8'h0C, 32'h0, 32'h0},
    {2'd1, 4'd7, 8'h10, 32'h0, 32'h0000_0098}           // R7 idle status
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got %h expected %h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  b;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    check("R1 reset rdata", bus_rdata, 32'h0);
    check("R9 reset irq", {31'b0, irq}, 32'h0);
    check("R3 reset frame_start", {31'b0, frame_start}, 32'h0);
    check("R10 reset tx_nonempty", {31'b0, tx_nonempty}, 32'h0);
    rd(8'h00, d); check("R1 reset ctrl", d, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][77:76] == 2'd0) wr(VEC[i][71:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][71:64], d);
        n_chk++;
        if (d !== VEC[i][31:0]) begin
          n_bad++;
          $display("FAIL R%0d vector %0d: got %h expected %h", VEC[i][75:72], i, d, VEC[i][31:0]);
        end
      end
    end

    // R3 start pulse only with enable and master
    wr(8'h00, 32'h1); wr(8'h04, 32'h5); check("R3 no start without master", {31'b0, last_start}, 32'h0);
    wr(8'h00, 32'h3); wr(8'h04, 32'h6); check("R3 start pulse", {31'b0, last_start}, 32'h1);
    @(negedge clk); check("R3 pulse one cycle", {31'b0, frame_start}, 32'h0);
    wr(8'h50, 32'h0); check("R3 no start other reg", {31'b0, last_start}, 32'h0);

    // R4 byte ports
    wr(8'h44, 32'h1A2B_3CA5);
    pop_tx(b); check("R4 tx byte", {24'b0, b}, 32'hA5);
    check("R4 tx drained", {31'b0, tx_nonempty}, 32'h0);
    push_rx(8'h5C); rd(8'h40, d); check("R4 rx byte", d, 32'h5C);

    // R6 word ports act as byte ports with four-byte access clear
    wr(8'h4C, 32'h4433_2211);
    pop_tx(b); check("R6 word write one byte", {24'b0, b}, 32'h11);
    check("R6 only one byte pushed", {31'b0, tx_nonempty}, 32'h0);
    push_rx(8'h71); push_rx(8'h72); rd(8'h48, d); check("R6 word read one byte", d, 32'h71);
    rd(8'h40, d); check("R6 second byte kept", d, 32'h72);

    // R5 four-byte access
    wr(8'h00, 32'h0001_0003);
    rd(8'h10, d); check("R7 x4 status bit", d & 32'h100, 32'h100);
    wr(8'h4C, 32'h4433_2211);
    for (int k = 0; k < 4; k++) begin
      pop_tx(b); check("R5 tx word byte order", {24'b0, b}, 32'h11 * (k + 1));
    end
    push_rx(8'hA1); push_rx(8'hA2); push_rx(8'hA3);
    rd(8'h10, d); check("R7 x4 rx empty below four", d & 32'h10, 32'h10);
    rd(8'h48, d); check("R10 short word read zero", d, 32'h0);
    push_rx(8'hA4);
    rd(8'h10, d); check("R7 x4 rx not empty at four", d & 32'h10, 32'h0);
    rd(8'h48, d); check("R5 rx word", d, 32'hA4A3_A2A1);
    rd(8'h40, d); check("R10 empty byte read zero", d, 32'h0);

    // R7 four-byte full threshold, R6 byte port still one byte in x4
    for (int k = 0; k < 13; k++) wr(8'h44, 32'h30 + k);
    rd(8'h10, d); check("R7 x4 tx full at 3 free", d & 32'h28, 32'h20);
    wr(8'h4C, 32'hDEAD_BEEF);
    for (int k = 0; k < 13; k++) begin
      pop_tx(b); check("R10 dropped word kept order", {24'b0, b}, 32'h30 + k);
    end
    check("R10 word write dropped", {31'b0, tx_nonempty}, 32'h0);

    // R7 full flag and R10 drop in byte mode
    wr(8'h00, 32'h3);
    wr(8'h10, 32'h7);
    for (int k = 0; k < 16; k++) wr(8'h44, 32'h80 + k);
    rd(8'h10, d); check("R7 tx full", d & 32'h38, 32'h30);
    wr(8'h44, 32'hEE);
    for (int k = 0; k < 16; k++) begin
      pop_tx(b); check("R10 full fifo contents", {24'b0, b}, 32'h80 + k);
    end
    check("R10 write to full dropped", {31'b0, tx_nonempty}, 32'h0);
    seq_busy = 1'b1;
    rd(8'h10, d); check("R7 ready low while busy", d & 32'h80, 32'h0);
    seq_busy = 1'b0;

    // R8 sticky bits, R9 interrupt
    wr(8'h10, 32'h7);
    wr(8'h0C, 32'h1);
    @(negedge clk); seq_tx_done = 1'b1; @(negedge clk); seq_tx_done = 1'b0;
    @(negedge clk);
    check("R9 irq on enabled event", {31'b0, irq}, 32'h1);
    wr(8'h10, 32'h0);
    rd(8'h10, d); check("R8 write zero keeps", d & 32'h1, 32'h1);
    wr(8'h10, 32'h1);
    rd(8'h10, d); check("R8 write one clears", d & 32'h1, 32'h0);
    check("R9 irq drops", {31'b0, irq}, 32'h0);
    wr(8'h0C, 32'h0);
    @(negedge clk); seq_rx_done = 1'b1; @(negedge clk); seq_rx_done = 1'b0;
    push_rx(8'h01);
    repeat (2) @(negedge clk);
    check("R9 masked no irq", {31'b0, irq}, 32'h0);
    rd(8'h10, d); check("R8 rx done and arrival set", d & 32'h7, 32'h6);

    // R11 flush on enable falling
    wr(8'h44, 32'h9);
    wr(8'h00, 32'h2);
    @(negedge clk);
    check("R11 tx flushed", {31'b0, tx_nonempty}, 32'h0);
    rd(8'h10, d); check("R11 rx flushed", d & 32'h10, 32'h10);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule